// File: doc/BRIEF.md
# Scratchpad Request Front-End Queue

This block sits between instruction issue and a banked scratchpad memory. Each cycle it may receive one decoded load or store instruction that carries, for every lane, an effective byte address, a write word and a byte-enable mask. The instruction also carries a lane-activity mask, a size class (byte, halfword or word), a thread identifier and an opaque piggyback field. The block checks that every active lane is aligned to the access size and lies inside the scratchpad's byte range. Any violation turns into a registered trap request that carries a fixed handler address and the offending thread. A clean instruction is packed into a single record and pushed into a first-in first-out queue.

Whenever the scratchpad reports that it can take work and the queue holds something, the oldest record is read out and presented for one cycle on registered outputs. When the queue is full the block raises a stall output. An instruction offered while stall is high is dropped.

Top module: `spm_req_frontend`

## Requirements
- R1: While reset is held and after it is released, `trap_en`, `out_valid` and `stall` are low until an instruction is accepted or faults.
- R2: Size code 2'b10 or 2'b11 selects word access. Such an instruction traps if any active lane has either of address bits [1:0] set, and it is then not queued.
- R3: Size code 2'b01 selects halfword access. It traps only if an active lane has address bit 0 set. Bit 1 alone is legal.
- R4: Size code 2'b00 selects byte access, which never faults on alignment, odd addresses included.
- R5: A lane whose bit in `in_lmask` is 0 takes no part in the alignment or range checks.
- R6: An active lane whose address is at or above BANKS×ENTRIES×WORD_BYTES traps, at any size. The last byte below that limit is legal.
- R7: `trap_en` is high in the cycle after a valid faulting instruction and in no other cycle. At the same time `trap_pc` equals TRAP_VEC and `trap_tid` equals that instruction's `in_tid`.
- R8: An accepted instruction reappears on the `out_*` ports with its store flag, addresses, write data, byte masks, lane mask and piggyback unchanged, in arrival order. Lane i uses slice i of every per-lane vector.
- R9: `out_valid` is high for exactly the cycle after a clock edge at which `spm_ready` was high and the queue was non-empty. Each such edge removes one record. With `spm_ready` low nothing leaves.
- R10: `stall` is high while DEPTH records are held. An instruction offered while `stall` is high is discarded.
- R11: With `in_valid` low nothing is queued and no trap is raised, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_size | input | 2 | 00 byte, 01 halfword, 1x word |
| in_addr | input | LANES×AW | Per-lane byte address, lane i at [i*AW +: AW] |
| in_wdata | input | LANES×WORD_BYTES×8 | Per-lane write word |
| in_bmask | input | LANES×WORD_BYTES | Per-lane byte enables |
| in_lmask | input | LANES | Active-lane mask |
| in_tid | input | TID_W | Thread identifier |
| in_piggy | input | PB_W | Opaque data carried with the request |
| spm_ready | input | 1 | Scratchpad can accept a request |
| stall | output | 1 | Queue full |
| trap_en | output | 1 | Registered trap request |
| trap_pc | output | 32 | Trap handler address |
| trap_tid | output | TID_W | Thread of the faulting instruction |
| out_valid | output | 1 | Request presented this cycle |
| out_store | output | 1 | Store flag of the presented request |
| out_addr | output | LANES×AW | Per-lane addresses |
| out_wdata | output | LANES×WORD_BYTES×8 | Per-lane write data |
| out_bmask | output | LANES×WORD_BYTES | Per-lane byte enables |
| out_lmask | output | LANES | Active-lane mask |
| out_piggy | output | PB_W | Piggyback field |

## Verification
The bench uses four lanes, four banks of sixteen four-byte entries and a four-deep queue. That gives a 256-byte range inside a 10-bit address, so addresses just below and just above the limit can both be driven. A depth of four lets a handful of instructions reach the full condition, which exercises the stall and the dropped fifth request, and then drain in order. With only two thread-id bits, trap attribution is visible when consecutive faulting instructions carry different ids.

// File: rtl/spm_fe_pkg.sv
package spm_fe_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  // Alignment violation of one lane for a given size class.
  function automatic logic lane_misaligned(input logic [1:0] size, input logic [1:0] low_bits);
    logic bad;
    if (size[1])
      bad = |low_bits;
    else if (size == SZ_HALF)
      bad = low_bits[0];
    else
      bad = 1'b0;
    return bad;
  endfunction

endpackage

// File: rtl/spm_fe_check.sv
module spm_fe_check
  import spm_fe_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int AW        = 10,
  parameter int MEM_BYTES = 256
) (
  input  logic [1:0]          size,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    lmask,
  output logic                fault
);

  localparam logic [AW:0] LIMIT = (AW + 1)'(MEM_BYTES);

  logic [LANES-1:0] mis_lane;
  logic [LANES-1:0] oor_lane;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [AW-1:0] a;
      assign a           = addr[g*AW +: AW];
      assign mis_lane[g] = lmask[g] & lane_misaligned(size, a[1:0]);
      assign oor_lane[g] = lmask[g] & ({1'b0, a} >= LIMIT);
    end
  endgenerate

  assign fault = (|mis_lane) | (|oor_lane);

endmodule

// File: rtl/spm_fe_fifo.sv
module spm_fe_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             take,
  output logic             full,
  output logic             rvalid,
  output logic [WIDTH-1:0] rdata
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             pop;

  assign full = (count == CAP);
  assign pop  = take && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= pop;
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spm_req_frontend.sv
module spm_req_frontend
  import spm_fe_pkg::*;
#(
  parameter int          LANES      = 4,
  parameter int          BANKS      = 4,
  parameter int          ENTRIES    = 16,
  parameter int          WORD_BYTES = 4,
  parameter int          AW         = 10,
  parameter int          DEPTH      = 4,
  parameter int          TID_W      = 2,
  parameter int          PB_W       = 8,
  parameter logic [31:0] TRAP_VEC   = 32'h0000_0100
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic                          in_store,
  input  logic [1:0]                    in_size,
  input  logic [LANES*AW-1:0]           in_addr,
  input  logic [LANES*WORD_BYTES*8-1:0] in_wdata,
  input  logic [LANES*WORD_BYTES-1:0]   in_bmask,
  input  logic [LANES-1:0]              in_lmask,
  input  logic [TID_W-1:0]              in_tid,
  input  logic [PB_W-1:0]               in_piggy,
  input  logic                          spm_ready,
  output logic                          stall,
  output logic                          trap_en,
  output logic [31:0]                   trap_pc,
  output logic [TID_W-1:0]              trap_tid,
  output logic                          out_valid,
  output logic                          out_store,
  output logic [LANES*AW-1:0]           out_addr,
  output logic [LANES*WORD_BYTES*8-1:0] out_wdata,
  output logic [LANES*WORD_BYTES-1:0]   out_bmask,
  output logic [LANES-1:0]              out_lmask,
  output logic [PB_W-1:0]               out_piggy
);

  localparam int DW        = WORD_BYTES * 8;
  localparam int MEM_BYTES = BANKS * ENTRIES * WORD_BYTES;
  localparam int EW        = 1 + LANES * (AW + DW + WORD_BYTES) + LANES + PB_W;

  logic          fault;
  logic          full;
  logic          push;
  logic [EW-1:0] entry_in;
  logic [EW-1:0] entry_out;

  spm_fe_check #(
    .LANES    (LANES),
    .AW       (AW),
    .MEM_BYTES(MEM_BYTES)
  ) u_check (
    .size (in_size),
    .addr (in_addr),
    .lmask(in_lmask),
    .fault(fault)
  );

  assign push     = in_valid & ~fault & ~full;
  assign entry_in = {in_store, in_addr, in_wdata, in_bmask, in_lmask, in_piggy};

  spm_fe_fifo #(
    .WIDTH(EW),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (entry_in),
    .take  (spm_ready),
    .full  (full),
    .rvalid(out_valid),
    .rdata (entry_out)
  );

  assign stall = full;
  assign {out_store, out_addr, out_wdata, out_bmask, out_lmask, out_piggy} = entry_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_en  <= 1'b0;
      trap_pc  <= '0;
      trap_tid <= '0;
    end else begin
      trap_en <= in_valid & fault;
      if (in_valid & fault) begin
        trap_pc  <= TRAP_VEC;
        trap_tid <= in_tid;
      end
    end
  end

endmodule

// File: rtl/spm_fe_checker.sv
module spm_fe_checker #(
  parameter int TID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [TID_W-1:0] in_tid,
  input logic             push,
  input logic             spm_ready,
  input logic             stall,
  input logic             trap_en,
  input logic [TID_W-1:0] trap_tid,
  input logic             out_valid
);

  assert_trap_blocks_push_R2: assert property (@(posedge clk) disable iff (rst)
    trap_en |-> !$past(push));

  assert_trap_thread_R7: assert property (@(posedge clk) disable iff (rst)
    trap_en |-> (trap_tid == $past(in_tid)));

  assert_issue_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(spm_ready));

  assert_stall_from_input_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(in_valid));

  assert_idle_no_trap_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !trap_en);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!trap_en && !out_valid && !stall));

endmodule

bind spm_req_frontend spm_fe_checker #(.TID_W(TID_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_tid   (in_tid),
  .push     (push),
  .spm_ready(spm_ready),
  .stall    (stall),
  .trap_en  (trap_en),
  .trap_tid (trap_tid),
  .out_valid(out_valid)
);

// File: tb/spm_req_frontend_tb.sv
module spm_req_frontend_tb;

  localparam int LANES = 4;
  localparam int AW    = 10;
  localparam int WB    = 4;
  localparam int DW    = 32;
  localparam int TID_W = 2;
  localparam int PB_W  = 8;
  localparam int DEPTH = 4;
  localparam logic [31:0] TVEC = 32'h0000_0100;
  localparam int EW = 1 + LANES * (AW + DW + WB) + LANES + PB_W;

  logic                  clk = 1'b0;
  logic                  rst;
  logic                  in_valid, in_store;
  logic [1:0]            in_size;
  logic [LANES*AW-1:0]   in_addr;
  logic [LANES*DW-1:0]   in_wdata;
  logic [LANES*WB-1:0]   in_bmask;
  logic [LANES-1:0]      in_lmask;
  logic [TID_W-1:0]      in_tid;
  logic [PB_W-1:0]       in_piggy;
  logic                  spm_ready;
  logic                  stall, trap_en, out_valid, out_store;
  logic [31:0]           trap_pc;
  logic [TID_W-1:0]      trap_tid;
  logic [LANES*AW-1:0]   out_addr;
  logic [LANES*DW-1:0]   out_wdata;
  logic [LANES*WB-1:0]   out_bmask;
  logic [LANES-1:0]      out_lmask;
  logic [PB_W-1:0]       out_piggy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [EW-1:0] expq [$];

  always #2 clk = ~clk;

  spm_req_frontend #(
    .LANES(LANES), .BANKS(4), .ENTRIES(16), .WORD_BYTES(WB), .AW(AW),
    .DEPTH(DEPTH), .TID_W(TID_W), .PB_W(PB_W), .TRAP_VEC(TVEC)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_store(in_store), .in_size(in_size),
    .in_addr(in_addr), .in_wdata(in_wdata), .in_bmask(in_bmask), .in_lmask(in_lmask),
    .in_tid(in_tid), .in_piggy(in_piggy), .spm_ready(spm_ready), .stall(stall),
    .trap_en(trap_en), .trap_pc(trap_pc), .trap_tid(trap_tid), .out_valid(out_valid),
    .out_store(out_store), .out_addr(out_addr), .out_wdata(out_wdata),
    .out_bmask(out_bmask), .out_lmask(out_lmask), .out_piggy(out_piggy)
  );

  function automatic logic [LANES*AW-1:0] av(input int a0, input int a1, input int a2, input int a3);
    return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
  endfunction

  task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one instruction for one cycle; on return the registered trap is visible.
  task automatic issue(input string req, input logic v, input logic st, input logic [1:0] sz,
                       input logic [LANES*AW-1:0] a, input logic [LANES-1:0] lm,
                       input logic [TID_W-1:0] tid, input logic [PB_W-1:0] pb,
                       input logic exp_trap, input logic exp_acc);
    logic [LANES*DW-1:0] wd;
    logic [LANES*WB-1:0] bm;
    wd = {4{pb, 8'h5A, a[15:0]}} ^ {LANES*DW{st}};
    bm = {4{lm}};
    in_valid = v; in_store = st; in_size = sz; in_addr = a; in_wdata = wd;
    in_bmask = bm; in_lmask = lm; in_tid = tid; in_piggy = pb;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " trap_en"}, EW'(trap_en), EW'(exp_trap));
    if (exp_trap) begin
      check("R7 trap_pc", EW'(trap_pc), EW'(TVEC));
      check("R7 trap_tid", EW'(trap_tid), EW'(tid));
    end
    if (exp_acc) expq.push_back({st, a, wd, bm, lm, pb});
  endtask

  task automatic pop_expect(input string req);
    logic [EW-1:0] e;
    spm_ready = 1'b1;
    @(negedge clk);
    spm_ready = 1'b0;
    e = expq.pop_front();
    check({req, " out_valid"}, EW'(out_valid), EW'(1'b1));
    check({req, " record"}, {out_store, out_addr, out_wdata, out_bmask, out_lmask, out_piggy}, e);
  endtask

  task automatic expect_empty(input string req);
    spm_ready = 1'b1;
    @(negedge clk);
    spm_ready = 1'b0;
    check({req, " nothing left"}, EW'(out_valid), EW'(1'b0));
  endtask

  task automatic t_reset();
    check("R1 trap_en", EW'(trap_en), '0);
    check("R1 out_valid", EW'(out_valid), '0);
    check("R1 stall", EW'(stall), '0);
  endtask

  task automatic t_align_word_half();
    issue("R8 word store", 1, 1, 2'b10, av(0, 4, 8, 252), 4'hF, 2'd1, 8'hA1, 0, 1);
    issue("R2 word bit1", 1, 0, 2'b10, av(0, 4, 10, 12), 4'hF, 2'd2, 8'hA2, 1, 0);
    issue("R2 word bit0", 1, 0, 2'b11, av(1, 4, 8, 12), 4'hF, 2'd3, 8'hA3, 1, 0);
    issue("R3 half bit1 ok", 1, 0, 2'b01, av(2, 6, 0, 254), 4'hF, 2'd0, 8'hA4, 0, 1);
    issue("R3 half bit0", 1, 0, 2'b01, av(2, 3, 0, 8), 4'hF, 2'd1, 8'hA5, 1, 0);
    pop_expect("R8 first");
    pop_expect("R2 R8 second");
    expect_empty("R2 R9");
  endtask

  task automatic t_byte_range();
    issue("R4 byte odd", 1, 0, 2'b00, av(1, 3, 5, 255), 4'hF, 2'd2, 8'hB1, 0, 1);
    issue("R5 inactive lanes", 1, 1, 2'b10, av(0, 4, 7, 600), 4'h3, 2'd3, 8'hB2, 0, 1);
    issue("R6 out of range", 1, 0, 2'b00, av(0, 256, 5, 7), 4'hF, 2'd2, 8'hB3, 1, 0);
    issue("R11 valid low", 0, 0, 2'b10, av(1, 300, 3, 2), 4'hF, 2'd1, 8'hB4, 0, 0);
    check("R7 single-cycle trap", EW'(trap_en), '0);
    pop_expect("R4 R8");
    pop_expect("R5 R8");
    expect_empty("R6 R11");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      issue("R10 fill", 1, i[0], 2'b10, av(4*i, 16, 32, 48), 4'hF, TID_W'(i), PB_W'(8'hC0 + i), 0, 1);
      check("R9 held while not ready", EW'(out_valid), '0);
    end
    check("R10 stall high", EW'(stall), EW'(1'b1));
    issue("R10 dropped", 1, 0, 2'b10, av(8, 8, 8, 8), 4'hF, 2'd0, 8'hCF, 0, 0);
    for (int i = 0; i < DEPTH; i++) pop_expect("R9 R10 drain");
    check("R10 stall low", EW'(stall), '0);
    expect_empty("R10");
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_store = 1'b0; in_size = '0; in_addr = '0;
    in_wdata = '0; in_bmask = '0; in_lmask = '0; in_tid = '0; in_piggy = '0;
    spm_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_align_word_half();
    t_byte_range();
    t_full();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule